// File: doc/BRIEF.md
# Packet Receive Deframer

This block sits behind a symbol detector and turns its byte stream into a stored packet. It hunts for a run of zero preamble bytes followed by a start-of-frame delimiter, reads the length byte that follows, and writes every remaining frame byte (payload plus the two trailing check bytes) into a 64-word by 16-bit packet RAM. While the payload streams in, a 16-bit CRC is accumulated and, at the end, compared with the two check bytes, giving a pass/fail flag.

A timing window of fixed length opens on the delimiter. When it closes, the link-quality value presented on an input is captured. The host interrupt rises only once both the last byte has been stored and the window has closed. The interrupt and its status (length, CRC flag, link quality) then hold, and incoming bytes are dropped, until the host acknowledges. The host reads the stored bytes through a synchronous RAM read port.

Top module: `rxdf_top`

## Requirements
- R1: The delimiter byte 0xA7 is recognised only when at least four consecutive 0x00 bytes precede it; a delimiter after fewer zeros, or any other non-zero byte, restarts the zero count.
- R2: The byte after the delimiter gives the number of bytes that follow (payload plus two check bytes); values 2 to 127 are accepted and reported on `rx_len` with the interrupt.
- R3: A length byte below 2 or above 127 abandons the frame, raises no interrupt and resumes the delimiter hunt.
- R4: Frame byte n (counting from the first byte after the length) is stored at word n/2, in bits [7:0] when n is even and bits [15:8] when n is odd; the high half of a final unpaired word is 0x00. `rd_data` shows the word at `rd_addr` one clock later.
- R5: `crc_ok` is 1 exactly when the CRC (polynomial x^16+x^12+x^5+1, reflected form 0x8408, initial value 0, bits taken LSB first) over the payload equals {second check byte, first check byte}.
- R6: `lqi_val` reports the value `lqi_in` had at the clock edge that lies CLK_MHZ*64 edges after the edge that accepted the delimiter.
- R7: `irq` rises one clock after the later of the last-byte edge and the window-closing edge; `crc_ok`, `rx_len` and `lqi_val` are valid from that cycle and stay stable while `irq` is high.
- R8: While `irq` is high, input bytes are ignored and the RAM is not written; `irq` stays high until `irq_ack` is seen, falls on the next edge, and the hunt then restarts.
- R9: After reset `irq`, `crc_ok`, `rx_len` and `lqi_val` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_vld | input | 1 | Byte strobe from the symbol detector |
| rx_byte | input | 8 | Received byte, valid with `rx_vld` |
| lqi_in | input | LQI_W | Link-quality measurement, sampled at window close |
| irq_ack | input | 1 | Host acknowledge of the packet interrupt |
| rd_addr | input | 6 | Host read address into the packet RAM |
| rd_data | output | 16 | Registered read data |
| irq | output | 1 | Packet-stored interrupt, level |
| crc_ok | output | 1 | CRC comparison result |
| rx_len | output | 7 | Accepted length byte |
| lqi_val | output | LQI_W | Captured link-quality value |

## Verification
The assertions assume the host pulses `irq_ack` only while `irq` is high and that reset is held for at least one edge before traffic begins. The bench only acknowledges after seeing the interrupt, and drives bytes with idle cycles between them on the falling edge. Stimulus covers short preambles, illegal length bytes, corrupted check bytes and a full frame sent while a packet is pending, all compared against a cycle-level reference model.

// File: rtl/rxdf_pkg.sv
package rxdf_pkg;
  localparam logic [7:0] SFD_CODE  = 8'hA7;
  localparam int         PRE_ZEROS = 4;
  localparam int         FRAME_MIN = 2;
  localparam int         FRAME_MAX = 127;
  localparam int         LEN_W     = $clog2(FRAME_MAX + 1);
  localparam int         RAM_DW    = 16;
  localparam int         RAM_AW    = $clog2((FRAME_MAX + 1) / 2);
  localparam logic [15:0] CRC_POLY = 16'h8408;

  typedef enum logic [2:0] {
    ST_HUNT,
    ST_LEN,
    ST_BODY,
    ST_WAIT,
    ST_HOLD
  } rx_state_t;

  // One byte through the reflected CRC, least significant bit first.
  function automatic logic [15:0] crc_byte(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    logic        fb;
    r = c;
    for (int i = 0; i < 8; i++) begin
      fb = r[0] ^ b[i];
      r  = {1'b0, r[15:1]};
      if (fb) r = r ^ CRC_POLY;
    end
    return r;
  endfunction
endpackage

// File: rtl/rxdf_hunt.sv
module rxdf_hunt #(
  parameter int         NZERO = 4,
  parameter logic [7:0] DELIM = 8'hA7
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       in_vld,
  input  logic [7:0] in_byte,
  output logic       hit
);
  localparam int ZW = $clog2(NZERO + 1);
  localparam logic [ZW-1:0] ZMAX = ZW'(NZERO);

  logic [ZW-1:0] zcnt;

  assign hit = en && in_vld && (in_byte == DELIM) && (zcnt == ZMAX);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      zcnt <= '0;
    end else if (in_vld) begin
      if (in_byte != 8'h00) begin
        zcnt <= '0;
      end else if (zcnt != ZMAX) begin
        zcnt <= zcnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rxdf_lqi_win.sv
module rxdf_lqi_win #(
  parameter int WIN_CYC = 1024,
  parameter int LQI_W   = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             cancel,
  input  logic [LQI_W-1:0] lqi_in,
  output logic             done,
  output logic [LQI_W-1:0] lqi_q
);
  localparam int CW = $clog2(WIN_CYC + 1);

  logic [CW-1:0] cnt;
  logic          run;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      run   <= 1'b0;
      done  <= 1'b0;
      lqi_q <= '0;
    end else if (start) begin
      cnt  <= CW'(WIN_CYC - 1);
      run  <= 1'b1;
      done <= 1'b0;
    end else if (cancel) begin
      run  <= 1'b0;
      done <= 1'b0;
    end else if (run) begin
      if (cnt == '0) begin
        run   <= 1'b0;
        done  <= 1'b1;
        lqi_q <= lqi_in;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/rxdf_crc16.sv
module rxdf_crc16 import rxdf_pkg::*; (
  input  logic        clk,
  input  logic        rst,
  input  logic        clr,
  input  logic        en,
  input  logic [7:0]  din,
  output logic [15:0] crc
);
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      crc <= 16'h0000;
    end else if (en) begin
      crc <= crc_byte(crc, din);
    end
  end
endmodule

// File: rtl/rxdf_pkt_ram.sv
module rxdf_pkt_ram #(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/rxdf_top.sv
module rxdf_top import rxdf_pkg::*; #(
  parameter int CLK_MHZ = 16,
  parameter int WIN_US  = 64,
  parameter int LQI_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_vld,
  input  logic [7:0]        rx_byte,
  input  logic [LQI_W-1:0]  lqi_in,
  input  logic              irq_ack,
  input  logic [RAM_AW-1:0] rd_addr,
  output logic [RAM_DW-1:0] rd_data,
  output logic              irq,
  output logic              crc_ok,
  output logic [LEN_W-1:0]  rx_len,
  output logic [LQI_W-1:0]  lqi_val
);
  localparam int WIN_CYC = CLK_MHZ * WIN_US;

  rx_state_t         st;
  logic              sfd_hit;
  logic              win_done;
  logic [LQI_W-1:0]  win_lqi;
  logic [15:0]       crc_val;
  logic [LEN_W-1:0]  len_q;
  logic [LEN_W-1:0]  idx_q;
  logic [7:0]        lo_q;
  logic [7:0]        fcs_lo;
  logic [7:0]        fcs_hi;
  logic              len_bad;
  logic              body_byte;
  logic              last_byte;
  logic              crc_en;
  logic              win_cancel;
  logic              ram_we;
  logic [RAM_AW-1:0] ram_wa;
  logic [RAM_DW-1:0] ram_wd;

  always_comb begin
    len_bad    = (rx_byte < 8'(FRAME_MIN)) || (rx_byte > 8'(FRAME_MAX));
    body_byte  = (st == ST_BODY) && rx_vld;
    last_byte  = body_byte && (idx_q == len_q - LEN_W'(1));
    crc_en     = body_byte && (idx_q < len_q - LEN_W'(2));
    win_cancel = ((st == ST_LEN) && rx_vld && len_bad) ||
                 ((st == ST_HOLD) && irq_ack);
    ram_we     = body_byte && (idx_q[0] || last_byte);
    ram_wa     = idx_q[LEN_W-1:1];
    ram_wd     = idx_q[0] ? {rx_byte, lo_q} : {8'h00, rx_byte};
  end

  rxdf_hunt #(
    .NZERO (PRE_ZEROS),
    .DELIM (SFD_CODE)
  ) hunt_i (
    .clk     (clk),
    .rst     (rst),
    .en      (st == ST_HUNT),
    .in_vld  (rx_vld),
    .in_byte (rx_byte),
    .hit     (sfd_hit)
  );

  rxdf_lqi_win #(
    .WIN_CYC (WIN_CYC),
    .LQI_W   (LQI_W)
  ) win_i (
    .clk    (clk),
    .rst    (rst),
    .start  (sfd_hit),
    .cancel (win_cancel),
    .lqi_in (lqi_in),
    .done   (win_done),
    .lqi_q  (win_lqi)
  );

  rxdf_crc16 crc_i (
    .clk (clk),
    .rst (rst),
    .clr (sfd_hit),
    .en  (crc_en),
    .din (rx_byte),
    .crc (crc_val)
  );

  rxdf_pkt_ram #(
    .AW (RAM_AW),
    .DW (RAM_DW)
  ) ram_i (
    .clk   (clk),
    .we    (ram_we),
    .waddr (ram_wa),
    .wdata (ram_wd),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_HUNT;
      len_q   <= '0;
      idx_q   <= '0;
      lo_q    <= '0;
      fcs_lo  <= '0;
      fcs_hi  <= '0;
      irq     <= 1'b0;
      crc_ok  <= 1'b0;
      rx_len  <= '0;
      lqi_val <= '0;
    end else begin
      unique case (st)
        ST_HUNT: begin
          if (sfd_hit) st <= ST_LEN;
        end
        ST_LEN: begin
          if (rx_vld) begin
            if (len_bad) begin
              st <= ST_HUNT;
            end else begin
              len_q <= rx_byte[LEN_W-1:0];
              idx_q <= '0;
              st    <= ST_BODY;
            end
          end
        end
        ST_BODY: begin
          if (rx_vld) begin
            lo_q  <= rx_byte;
            idx_q <= idx_q + 1'b1;
            if (idx_q == len_q - LEN_W'(2)) fcs_lo <= rx_byte;
            if (last_byte) begin
              fcs_hi <= rx_byte;
              st     <= ST_WAIT;
            end
          end
        end
        ST_WAIT: begin
          if (win_done) begin
            irq     <= 1'b1;
            crc_ok  <= (crc_val == {fcs_hi, fcs_lo});
            rx_len  <= len_q;
            lqi_val <= win_lqi;
            st      <= ST_HOLD;
          end
        end
        ST_HOLD: begin
          if (irq_ack) begin
            irq <= 1'b0;
            st  <= ST_HUNT;
          end
        end
        default: st <= ST_HUNT;
      endcase
    end
  end
endmodule

// File: rtl/rxdf_chk.sv
module rxdf_chk #(
  parameter int LQI_W = 8,
  parameter int LW    = 7
) (
  input logic             clk,
  input logic             rst,
  input logic             irq,
  input logic             irq_ack,
  input logic             crc_ok,
  input logic [LW-1:0]    rx_len,
  input logic [LQI_W-1:0] lqi_val,
  input logic             wr_en
);
  p_irq_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (irq && !irq_ack) |=> irq);

  p_ack_release_r8: assert property (@(posedge clk) disable iff (rst)
    (irq && irq_ack) |=> !irq);

  p_no_store_pending_r8: assert property (@(posedge clk) disable iff (rst)
    irq |-> !wr_en);

  p_status_stable_r7: assert property (@(posedge clk) disable iff (rst)
    (irq && !irq_ack) |=> ($stable(crc_ok) && $stable(rx_len) && $stable(lqi_val)));

  p_len_legal_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> (rx_len >= LW'(2)));

  p_reset_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!irq && !crc_ok && rx_len == '0 && lqi_val == '0));
endmodule

bind rxdf_top rxdf_chk #(
  .LQI_W (LQI_W),
  .LW    (rxdf_pkg::LEN_W)
) chk_i (
  .clk     (clk),
  .rst     (rst),
  .irq     (irq),
  .irq_ack (irq_ack),
  .crc_ok  (crc_ok),
  .rx_len  (rx_len),
  .lqi_val (lqi_val),
  .wr_en   (ram_we)
);

// File: tb/rxdf_top_tb_top.sv
module rxdf_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TB_MHZ     = 1;
  localparam int WIN        = TB_MHZ * 64;

  typedef logic [7:0] u8_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rx_vld = 1'b0;
  logic [7:0]  rx_byte = 8'h00;
  logic [7:0]  lqi_in = 8'h00;
  logic        irq_ack = 1'b0;
  logic [5:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        irq;
  logic        crc_ok;
  logic [6:0]  rx_len;
  logic [7:0]  lqi_val;

  int n_chk  = 0;
  int n_fail = 0;
  bit ended  = 1'b0;

  u8_t last_body[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  rxdf_top #(.CLK_MHZ(TB_MHZ), .WIN_US(64), .LQI_W(8)) dut_i (
    .clk(clk), .rst(rst), .rx_vld(rx_vld), .rx_byte(rx_byte), .lqi_in(lqi_in),
    .irq_ack(irq_ack), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq),
    .crc_ok(crc_ok), .rx_len(rx_len), .lqi_val(lqi_val)
  );

  always @(negedge clk) lqi_in <= lqi_in + 8'd13;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  function automatic logic [15:0] ref_crc(input u8_t q[$], input int n);
    logic [15:0] c = 16'h0000;
    for (int k = 0; k < n; k++) begin
      for (int b = 0; b < 8; b++) begin
        logic fb;
        fb = c[0] ^ q[k][b];
        c  = c >> 1;
        if (fb) c = c ^ 16'h8408;
      end
    end
    return c;
  endfunction

  // Reference model: behavioural, event-time based
  int  m_state = 0;
  int  m_zeros = 0;
  int  m_cyc   = 0;
  int  m_sfd   = -100000;
  int  m_len   = 0;
  u8_t m_q[$];
  bit  m_irq   = 1'b0;
  bit  m_crc   = 1'b0;
  int  m_rlen  = 0;
  int  m_lqi   = 0;
  int  m_cap   = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_state = 0; m_zeros = 0; m_cyc = 0; m_sfd = -100000;
      m_irq = 1'b0; m_crc = 1'b0; m_rlen = 0; m_lqi = 0;
    end else begin
      m_cyc++;
      if (m_cyc == m_sfd + WIN) m_cap = int'(lqi_in);
      case (m_state)
        0: if (rx_vld) begin
             if (rx_byte == 8'hA7 && m_zeros >= 4) begin
               m_state = 1; m_sfd = m_cyc;
             end else if (rx_byte == 8'h00) begin
               if (m_zeros < 4) m_zeros++;
             end else begin
               m_zeros = 0;
             end
           end
        1: if (rx_vld) begin
             if (rx_byte < 2 || rx_byte > 127) begin
               m_state = 0; m_zeros = 0;
             end else begin
               m_len = int'(rx_byte); m_q.delete(); m_state = 2;
             end
           end
        2: if (rx_vld) begin
             m_q.push_back(rx_byte);
             if (m_q.size() == m_len) m_state = 3;
           end
        3: if (m_cyc > m_sfd + WIN) begin
             m_irq  = 1'b1;
             m_rlen = m_len;
             m_lqi  = m_cap;
             m_crc  = (ref_crc(m_q, m_len - 2) == {m_q[m_len-1], m_q[m_len-2]});
             m_state = 4;
           end
        4: if (irq_ack) begin
             m_irq = 1'b0; m_state = 0; m_zeros = 0;
           end
        default: m_state = 0;
      endcase
    end
  end

  // Every-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      check(irq == m_irq, "R7 irq timing", int'(irq), int'(m_irq));
      if (m_irq && irq) begin
        check(crc_ok == m_crc, "R5 crc flag", int'(crc_ok), int'(m_crc));
        check(int'(rx_len) == m_rlen, "R2 length", int'(rx_len), m_rlen);
        check(int'(lqi_val) == m_lqi, "R6 link quality", int'(lqi_val), m_lqi);
      end
    end
  end

  task automatic send_byte(input u8_t b);
    @(negedge clk);
    rx_vld  = 1'b1;
    rx_byte = b;
    @(negedge clk);
    rx_vld  = 1'b0;
  endtask

  task automatic send_frame(input int npre, input int npay, input int seed,
                            input bit corrupt, input int len_force, input int nsend);
    u8_t body[$];
    logic [15:0] c;
    int lenb;
    for (int k = 0; k < npay; k++) body.push_back(u8_t'((k * 37 + seed) & 255));
    c = ref_crc(body, npay);
    body.push_back(c[7:0] ^ (corrupt ? 8'h01 : 8'h00));
    body.push_back(c[15:8]);
    lenb = (len_force >= 0) ? len_force : npay + 2;
    for (int k = 0; k < npre; k++) send_byte(8'h00);
    send_byte(8'hA7);
    send_byte(u8_t'(lenb));
    for (int k = 0; k < nsend && k < body.size(); k++) send_byte(body[k]);
    if (len_force < 0) last_body = body;
  endtask

  task automatic wait_irq(input string req);
    int t = 0;
    while (!irq && t < 600) begin
      @(negedge clk);
      t++;
    end
    check(irq == 1'b1, req, int'(irq), 1);
  endtask

  task automatic ack();
    @(negedge clk);
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
  endtask

  task automatic check_ram(input string req);
    int n = last_body.size();
    for (int w = 0; w < (n + 1) / 2; w++) begin
      logic [15:0] exp;
      exp[7:0]  = last_body[2*w];
      exp[15:8] = (2*w + 1 < n) ? last_body[2*w+1] : 8'h00;
      @(negedge clk);
      rd_addr = 6'(w);
      @(negedge clk);
      check(rd_data == exp, req, int'(rd_data), int'(exp));
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    check(irq == 1'b0, "R9 irq", int'(irq), 0);
    check(crc_ok == 1'b0, "R9 crc_ok", int'(crc_ok), 0);
    check(rx_len == 7'd0, "R9 rx_len", int'(rx_len), 0);
    check(lqi_val == 8'd0, "R9 lqi_val", int'(lqi_val), 0);

    // Short frame: window closes after last byte (R6, R7, R4, R5)
    send_frame(4, 3, 5, 1'b0, -1, 200);
    wait_irq("R7 short frame irq");
    check(crc_ok == 1'b1, "R5 good crc short", int'(crc_ok), 1);
    check_ram("R4 short frame ram");
    ack();
    idle(3);
    check(irq == 1'b0, "R8 released after ack", int'(irq), 0);

    // Longest frame: last byte after window close
    send_frame(6, 125, 11, 1'b0, -1, 200);
    wait_irq("R7 long frame irq");
    check(rx_len == 7'd127, "R2 max length", int'(rx_len), 127);
    check_ram("R4 long frame ram");
    ack();

    // Corrupted check byte
    send_frame(4, 20, 3, 1'b1, -1, 200);
    wait_irq("R5 bad frame irq");
    check(crc_ok == 1'b0, "R5 bad crc", int'(crc_ok), 0);
    ack();

    // Minimum length: empty payload, check bytes zero
    send_frame(4, 0, 0, 1'b0, -1, 200);
    wait_irq("R2 min length irq");
    check(crc_ok == 1'b1 && rx_len == 7'd2, "R2 min length", int'(rx_len), 2);
    check_ram("R4 odd-free min frame");
    ack();

    // Illegal length bytes abort
    send_frame(4, 4, 9, 1'b0, 1, 0);
    idle(150);
    check(irq == 1'b0, "R3 length 1 aborts", int'(irq), 0);
    send_frame(4, 4, 9, 1'b0, 200, 0);
    idle(150);
    check(irq == 1'b0, "R3 length 200 aborts", int'(irq), 0);

    // Only three preamble zeros: delimiter ignored
    send_frame(3, 4, 21, 1'b0, -1, 200);
    idle(150);
    check(irq == 1'b0, "R1 short preamble ignored", int'(irq), 0);

    // Good frame, then a full frame while pending is ignored
    send_frame(5, 9, 41, 1'b0, -1, 200);
    wait_irq("R1 frame after hunt restart");
    begin
      u8_t keep[$];
      keep = last_body;
      send_frame(4, 6, 77, 1'b0, -1, 200);
      last_body = keep;
    end
    check(irq == 1'b1 && rx_len == 7'd11, "R8 pending frame kept", int'(rx_len), 11);
    check_ram("R8 ram untouched while pending");
    ack();
    idle(150);
    check(irq == 1'b0, "R8 dropped frame not reported", int'(irq), 0);

    idle(5);
    finish_run();
  end
endmodule